// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache placed between a pipelined processor and a slow memory that only moves whole lines. It holds 32 data words as four sets of two lines, each line four words wide, and it takes word addresses. A request that hits answers on the next clock edge, and the processor is never stalled. A request that misses stalls the processor while the cache fetches the missing line. If the line being replaced has been modified, the cache first copies that line back to memory.

Writes follow a write-back, write-allocate policy. A write hit changes only the cached word and marks its line as modified. A write miss first brings the line in, then merges the new word into it. Each set keeps one recency bit that picks which way to replace. Two counters, one for accepted requests and one for hits, let the hit ratio be computed as hits divided by requests.

Top module: `dcache2w`

## Requirements
- R1: The word address splits into fields as follows. Bits [1:0] select the word in a line, bits [3:2] select the set, and all higher bits form the tag. A line fill and a writeback always use the line base address, which has bits [1:0] equal to zero. In a memory line, word k sits at bits [32k+31:32k].
- R2: A read hit raises `cpu_rsp_valid` in the cycle after the request is accepted, with the addressed word on `cpu_rdata`. `cpu_ready` stays high and no memory request is issued.
- R3: A write hit changes only the addressed word. The other three words of the line read back unchanged, and the line is marked modified, so a later eviction writes the new word back to memory.
- R4: After a request that misses is accepted, `cpu_ready` is low from the next cycle until the response. The cache issues a single four-word line read at the line base address. For a clean victim the response arrives 6 cycles after acceptance, carrying the memory word, and `cpu_ready` returns high.
- R5: On a miss, the victim is an invalid way if one exists. Otherwise it is the way the set's recency bit names. Every hit or fill in a set points that bit at the other way.
- R6: A victim that is both valid and modified is written back with a line write request before the line read request starts, never overlapping it. Against the 6-cycle memory, the response then arrives 13 cycles after acceptance. A clean victim causes no writeback.
- R7: A write miss fetches the line, places the new word into it, and leaves the rest of the line as it is in memory. The line is marked modified.
- R8: `access_count` rises by one for every accepted request, and `hit_count` rises by one for every accepted request that hits.
- R9: After reset, `cpu_ready` is high, `mem_req` and `cpu_rsp_valid` are low, both counters are zero, and every line is invalid, so the first access misses.
- R10: A request presented while `cpu_ready` is low is ignored. It changes no cached data and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken on an edge where `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | High when the cache can take a request |
| cpu_rsp_valid | output | 1 | One-cycle pulse marking completion of a request |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_rsp_valid` for reads |
| mem_req | output | 1 | Line request, held until `mem_ready` |
| mem_we | output | 1 | 1 = line writeback, 0 = line fill |
| mem_addr | output | ADDR_W | Line base word address |
| mem_wline | output | DATA_W*LINE_WORDS | Line being written back |
| mem_rline | input | DATA_W*LINE_WORDS | Fill line, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle completion pulse of a line request |
| hit_count | output | CNT_W | Number of hits |
| access_count | output | CNT_W | Number of accepted requests |

## Verification
The assertions rely on the memory side behaving well. `mem_ready` is expected to pulse for exactly one cycle, and only while a request is pending. A pulse outside a request would be read as a completed fill or writeback. The processor side is assumed to hold a request for exactly one accepted edge. The bench's memory model only raises `mem_ready` after counting six cycles of a held request, and it lowers the pulse on the following cycle. The processor tasks drive each request for one cycle only. The one exception is the stall test, which deliberately presents a second request while `cpu_ready` is low.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } dc_state_e;

  // prefer an empty way, otherwise follow the recency bit
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

endpackage

// File: rtl/dc_word_bank.sv
module dc_word_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register holds its value while re is low
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dc_tag_store.sv
module dc_tag_store
  import dc_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             vict_way,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag,
  input  logic             upd_en,
  input  logic             upd_install,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_dirty
);

  localparam int NUM_SETS = 1 << IDX_W;
  localparam int NUM_WAYS = 2;

  logic [NUM_WAYS-1:0][NUM_SETS-1:0] valid_q;
  logic [NUM_WAYS-1:0][NUM_SETS-1:0] dirty_q;
  logic [NUM_SETS-1:0]               lru_q;
  logic [TAG_W-1:0]                  tag_q [NUM_WAYS][NUM_SETS];
  logic [NUM_WAYS-1:0]               match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
  end

  assign hit        = |match;
  assign hit_way    = match[1];
  assign vict_way   = pick_victim(valid_q[0][lk_idx], valid_q[1][lk_idx], lru_q[lk_idx]);
  assign vict_dirty = valid_q[vict_way][lk_idx] && dirty_q[vict_way][lk_idx];
  assign vict_tag   = tag_q[vict_way][lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      lru_q   <= '0;
    end else if (upd_en) begin
      lru_q[upd_idx] <= ~upd_way;
      if (upd_install) begin
        valid_q[upd_way][upd_idx] <= 1'b1;
        dirty_q[upd_way][upd_idx] <= upd_dirty;
      end else if (upd_dirty) begin
        dirty_q[upd_way][upd_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_install) tag_q[upd_way][upd_idx] <= upd_tag;
  end

  // R5
  one_way_match_chk: assert property (@(posedge clk) disable iff (rst)
    !(match[0] && match[1]));

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [OFF_W-1:0]  cpu_off,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hit,
  input  logic              hit_way,
  input  logic              vict_way,
  input  logic              vict_dirty,
  input  logic [TAG_W-1:0]  vict_tag,
  input  logic              mem_ready,
  output logic              accept,
  output logic              fill_done,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              q_we,
  output logic [OFF_W-1:0]  q_off,
  output logic [IDX_W-1:0]  q_idx,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_way,
  output logic              upd_en,
  output logic              upd_install,
  output logic              upd_way,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [TAG_W-1:0]  upd_tag,
  output logic              upd_dirty
);

  localparam logic [OFF_W-1:0] OFF_ZERO = '0;

  dc_state_e        state_q;
  logic [TAG_W-1:0] q_tag;

  assign accept    = cpu_req && cpu_ready;
  assign fill_done = (state_q == ST_FILL) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cpu_ready <= 1'b1;
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= (accept && hit) || fill_done;
      case (state_q)
        ST_IDLE: begin
          if (accept && !hit) begin
            cpu_ready <= 1'b0;
            mem_req   <= 1'b1;
            if (vict_dirty) begin
              state_q  <= ST_WB;
              mem_we   <= 1'b1;
              mem_addr <= {vict_tag, cpu_idx, OFF_ZERO};
            end else begin
              state_q  <= ST_FILL;
              mem_we   <= 1'b0;
              mem_addr <= {cpu_tag, cpu_idx, OFF_ZERO};
            end
          end
        end
        ST_WB: begin
          if (mem_ready) begin
            state_q  <= ST_FILL;
            mem_we   <= 1'b0;
            mem_addr <= {q_tag, q_idx, OFF_ZERO};
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            state_q   <= ST_IDLE;
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // pending request, captured on every accepted edge
  always_ff @(posedge clk) begin
    if (accept) begin
      q_we    <= cpu_we;
      q_off   <= cpu_off;
      q_idx   <= cpu_idx;
      q_tag   <= cpu_tag;
      q_wdata <= cpu_wdata;
      q_way   <= vict_way;
    end
  end

  always_comb begin
    upd_en      = (accept && hit) || fill_done;
    upd_install = fill_done;
    upd_way     = fill_done ? q_way : hit_way;
    upd_idx     = fill_done ? q_idx : cpu_idx;
    upd_tag     = q_tag;
    upd_dirty   = fill_done ? q_we : cpu_we;
  end

  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (!cpu_ready && mem_req));

  // R2
  hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (rsp_valid && cpu_ready && !mem_req));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (state_q == ST_IDLE));

endmodule

// File: rtl/dc_stat.sv
module dc_stat #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_inc,
  input  logic             hit_inc,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] hit_cnt
);

  // both counters stop at all-ones; the access count reaches it first
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      hit_cnt <= '0;
    end else begin
      if (acc_inc && (acc_cnt != '1)) acc_cnt <= acc_cnt + 1'b1;
      if (hit_inc && (hit_cnt != '1)) hit_cnt <= hit_cnt + 1'b1;
    end
  end

  // R8
  hit_le_acc_chk: assert property (@(posedge clk) disable iff (rst)
    hit_cnt <= acc_cnt);

  // R8
  hit_needs_acc_chk: assert property (@(posedge clk) disable iff (rst)
    hit_inc |-> acc_inc);

endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int LINE_WORDS = 4,
  parameter int NUM_SETS   = 4,
  parameter int CNT_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_rsp_valid,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W*LINE_WORDS-1:0] mem_wline,
  input  logic [DATA_W*LINE_WORDS-1:0] mem_rline,
  input  logic                         mem_ready,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             access_count
);

  localparam int OFF_W     = $clog2(LINE_WORDS);
  localparam int IDX_W     = $clog2(NUM_SETS);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int RAM_DEPTH = 2 * NUM_SETS;
  localparam int RAM_AW    = IDX_W + 1;

  logic [OFF_W-1:0] cpu_off;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;

  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  logic             hit, hit_way, vict_way, vict_dirty;
  logic [TAG_W-1:0] vict_tag;
  logic             accept, fill_done;
  logic             q_we, q_way;
  logic [OFF_W-1:0] q_off;
  logic [IDX_W-1:0] q_idx;
  logic [DATA_W-1:0] q_wdata;
  logic             upd_en, upd_install, upd_way, upd_dirty;
  logic [IDX_W-1:0] upd_idx;
  logic [TAG_W-1:0] upd_tag;

  dc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk         (clk),
    .rst         (rst),
    .lk_idx      (cpu_idx),
    .lk_tag      (cpu_tag),
    .hit         (hit),
    .hit_way     (hit_way),
    .vict_way    (vict_way),
    .vict_dirty  (vict_dirty),
    .vict_tag    (vict_tag),
    .upd_en      (upd_en),
    .upd_install (upd_install),
    .upd_idx     (upd_idx),
    .upd_way     (upd_way),
    .upd_tag     (upd_tag),
    .upd_dirty   (upd_dirty)
  );

  dc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_off     (cpu_off),
    .cpu_idx     (cpu_idx),
    .cpu_tag     (cpu_tag),
    .cpu_wdata   (cpu_wdata),
    .hit         (hit),
    .hit_way     (hit_way),
    .vict_way    (vict_way),
    .vict_dirty  (vict_dirty),
    .vict_tag    (vict_tag),
    .mem_ready   (mem_ready),
    .accept      (accept),
    .fill_done   (fill_done),
    .cpu_ready   (cpu_ready),
    .rsp_valid   (cpu_rsp_valid),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .q_we        (q_we),
    .q_off       (q_off),
    .q_idx       (q_idx),
    .q_wdata     (q_wdata),
    .q_way       (q_way),
    .upd_en      (upd_en),
    .upd_install (upd_install),
    .upd_way     (upd_way),
    .upd_idx     (upd_idx),
    .upd_tag     (upd_tag),
    .upd_dirty   (upd_dirty)
  );

  dc_stat #(.CNT_W(CNT_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .acc_inc (accept),
    .hit_inc (accept && hit),
    .acc_cnt (access_count),
    .hit_cnt (hit_count)
  );

  // one RAM per word position; a fill writes all of them in one edge
  logic [DATA_W-1:0] bank_q    [LINE_WORDS];
  logic [DATA_W-1:0] fill_word [LINE_WORDS];
  logic [RAM_AW-1:0] rd_addr, wr_addr;

  assign rd_addr = {(hit ? hit_way : vict_way), cpu_idx};
  assign wr_addr = fill_done ? {q_way, q_idx} : {hit_way, cpu_idx};

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_bank
    logic bank_we;
    assign fill_word[k] = (q_we && (q_off == OFF_W'(k))) ? q_wdata
                                                         : mem_rline[k*DATA_W +: DATA_W];
    assign bank_we = fill_done ||
                     (accept && hit && cpu_we && (cpu_off == OFF_W'(k)));

    dc_word_bank #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .waddr (wr_addr),
      .wdata (fill_done ? fill_word[k] : cpu_wdata),
      .re    (accept),
      .raddr (rd_addr),
      .rdata (bank_q[k])
    );

    assign mem_wline[k*DATA_W +: DATA_W] = bank_q[k];
  end

  // after a fill the answer comes from a bypass register, not the RAM
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] byp_q;
  logic              byp_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_sel_q <= 1'b0;
      off_q     <= '0;
      byp_q     <= '0;
    end else if (accept) begin
      off_q     <= cpu_off;
      byp_sel_q <= 1'b0;
    end else if (fill_done) begin
      byp_q     <= fill_word[q_off];
      byp_sel_q <= 1'b1;
    end
  end

  assign cpu_rdata = byp_sel_q ? byp_q : bank_q[off_q];

  // R1
  line_base_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

endmodule

// File: tb/tb_dcache2w.sv
module tb_dcache2w;

  localparam int DW      = 32;
  localparam int AW      = 12;
  localparam int LW      = 4;
  localparam int LINE_W  = DW * LW;
  localparam int MEM_LAT = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              cpu_req, cpu_we;
  logic [AW-1:0]     cpu_addr;
  logic [DW-1:0]     cpu_wdata;
  logic              cpu_ready, cpu_rsp_valid;
  logic [DW-1:0]     cpu_rdata;
  logic              mem_req, mem_we, mem_ready;
  logic [AW-1:0]     mem_addr;
  logic [LINE_W-1:0] mem_wline, mem_rline;
  logic [31:0]       hit_count, access_count;

  always #4 clk = ~clk;

  dcache2w #(.DATA_W(DW), .ADDR_W(AW), .LINE_WORDS(LW), .NUM_SETS(4), .CNT_W(32)) dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ready(mem_ready),
    .hit_count(hit_count), .access_count(access_count)
  );

  int total = 0, bad = 0;
  int exp_acc = 0, exp_hit = 0;

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return 32'hA500_0000 | (32'(a) * 7);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // ---------------- line memory model ----------------
  logic [31:0]       mem [0:(1<<AW)-1];
  int                mcnt = 0, seq = 0, wb_cnt = 0, fill_cnt = 0, wb_seq = 0, fill_seq = 0;
  logic [AW-1:0]     last_wb_addr, last_fill_addr;
  logic [LINE_W-1:0] last_wb_line;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = pat(AW'(i));
    mem_ready = 1'b0;
    mem_rline = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_req) begin
        if (mcnt == MEM_LAT - 1) begin
          mcnt = 0;
          seq++;
          if (mem_we) begin
            for (int k = 0; k < LW; k++) mem[mem_addr + AW'(k)] = mem_wline[k*DW +: DW];
            wb_cnt++; wb_seq = seq; last_wb_addr = mem_addr; last_wb_line = mem_wline;
          end else begin
            for (int k = 0; k < LW; k++) mem_rline[k*DW +: DW] = mem[mem_addr + AW'(k)];
            fill_cnt++; fill_seq = seq; last_fill_addr = mem_addr;
          end
          mem_ready = 1'b1;
        end else mcnt++;
      end
    end
  end

  // ---------------- processor side ----------------
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                        input int exp_lat, input string req, output logic [31:0] rd);
    int lat;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    lat = 0;
    if (exp_lat > 0) check("R4", "ready low during miss", 32'(cpu_ready), 32'd0);
    while (!cpu_rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(req, $sformatf("latency of access %h", a), 32'(lat), 32'(exp_lat));
    rd = cpu_rdata;
    exp_acc++;
    if (exp_lat == 0) exp_hit++;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9", "ready after reset", 32'(cpu_ready), 32'd1);
    check("R9", "mem_req after reset", 32'(mem_req), 32'd0);
    check("R9", "rsp after reset", 32'(cpu_rsp_valid), 32'd0);
    check("R9", "access count after reset", access_count, 32'd0);
    check("R9", "hit count after reset", hit_count, 32'd0);
    // R1 R4: first read misses, fills line base 0x010 in 6 cycles
    access(1'b0, 12'h010, '0, 6, "R9", d);
    check("R4", "miss read data", d, pat(12'h010));
    check("R1", "fill line base", 32'(last_fill_addr), 32'h010);
    check("R4", "one fill", 32'(fill_cnt), 32'd1);
    check("R4", "ready back", 32'(cpu_ready), 32'd1);
  endtask

  task automatic t_read_hit();
    logic [31:0] d;
    access(1'b0, 12'h013, '0, 0, "R2", d);
    check("R2", "hit read data word3", d, pat(12'h013));
    check("R2", "no extra fill", 32'(fill_cnt), 32'd1);
    check("R8", "hit count", hit_count, 32'd1);
  endtask

  task automatic t_write_hit();
    logic [31:0] d;
    access(1'b1, 12'h011, 32'hDEAD_0001, 0, "R3", d);
    access(1'b0, 12'h011, '0, 0, "R3", d);
    check("R3", "written word", d, 32'hDEAD_0001);
    access(1'b0, 12'h012, '0, 0, "R3", d);
    check("R3", "neighbour word", d, pat(12'h012));
    access(1'b0, 12'h010, '0, 0, "R3", d);
    check("R3", "neighbour word0", d, pat(12'h010));
    check("R3", "no writeback on write hit", 32'(wb_cnt), 32'd0);
  endtask

  task automatic t_victim();
    logic [31:0] d;
    access(1'b0, 12'h020, '0, 6, "R5", d);        // free way 1
    check("R5", "data tag2", d, pat(12'h020));
    access(1'b0, 12'h010, '0, 0, "R5", d);        // tag1 kept
    access(1'b0, 12'h030, '0, 6, "R5", d);        // evicts tag2 (recency)
    check("R6", "clean victim no writeback", 32'(wb_cnt), 32'd0);
    access(1'b0, 12'h011, '0, 0, "R5", d);        // tag1 still present
    check("R5", "tag1 survives", d, 32'hDEAD_0001);
    access(1'b0, 12'h020, '0, 6, "R5", d);        // tag2 gone, evicts tag3
  endtask

  task automatic t_dirty_evict();
    logic [31:0] d;
    access(1'b0, 12'h040, '0, 13, "R6", d);       // evicts modified tag1
    check("R6", "data after writeback", d, pat(12'h040));
    check("R6", "one writeback", 32'(wb_cnt), 32'd1);
    check("R6", "writeback base", 32'(last_wb_addr), 32'h010);
    check("R3", "written word reached memory", last_wb_line[63:32], 32'hDEAD_0001);
    check("R3", "word0 written back", last_wb_line[31:0], pat(12'h010));
    check("R6", "writeback before fill", 32'(wb_seq < fill_seq), 32'd1);
    check("R6", "fill of new line", 32'(last_fill_addr), 32'h040);
  endtask

  task automatic t_write_miss();
    logic [31:0] d;
    int wb0;
    wb0 = wb_cnt;
    access(1'b1, 12'h105, 32'hBEEF_0105, 6, "R7", d);
    check("R7", "no writeback", 32'(wb_cnt), 32'(wb0));
    check("R7", "fill base", 32'(last_fill_addr), 32'h104);
    access(1'b0, 12'h105, '0, 0, "R7", d);
    check("R7", "merged word", d, 32'hBEEF_0105);
    access(1'b0, 12'h104, '0, 0, "R7", d);
    check("R7", "rest of line", d, pat(12'h104));
    access(1'b0, 12'h205, '0, 6, "R7", d);
    access(1'b0, 12'h305, '0, 13, "R7", d);       // evicts modified line
    check("R7", "writeback base", 32'(last_wb_addr), 32'h104);
    check("R7", "written-back word", last_wb_line[63:32], 32'hBEEF_0105);
    check("R7", "read after eviction", d, pat(12'h305));
  endtask

  task automatic t_stall_ignore();
    logic [31:0] d;
    int lat, acc0;
    acc0 = access_count;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h500;
    @(negedge clk);
    // R10: second request while stalled, targets a cached line
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 12'h041; cpu_wdata = 32'h0000_1234;
    check("R10", "ready low at injection", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R10", "miss latency unchanged", 32'(lat), 32'd6);
    check("R10", "miss data", cpu_rdata, pat(12'h500));
    check("R10", "stalled request not counted", access_count, 32'(acc0 + 1));
    exp_acc++;
    access(1'b0, 12'h041, '0, 0, "R10", d);
    check("R10", "ignored write left data", d, pat(12'h041));
  endtask

  task automatic t_counters();
    check("R8", "access count", access_count, 32'(exp_acc));
    check("R8", "hit count", hit_count, 32'(exp_hit));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_victim();
    t_dirty_evict();
    t_write_miss();
    t_stall_ignore();
    t_counters();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule